// File: doc/BRIEF.md
# Legacy System I/O Register Bank

This block is a small byte-wide register bank on an 8-bit port-mapped I/O bus. It answers a fixed set of port addresses. Three of them hold writable state: a soft-reset control, a system control register, and an I/O map type selector. Two return strap values taken from configuration inputs: an equipment byte and a board identifier. A few ports take writes and drop them. One port reads back as zero. Every other port reads as all ones.

The stored state drives three outputs. The soft-reset level follows the soft-reset flag. The non-contiguous I/O map output follows the map flag, which is set out of reset. A sticky error-halt output rises when software asks for byte-swapped (little-endian) operation, which the block does not support.

Bit positions follow a most-significant-first naming convention, so named bit n sits at value 1 << (7 − n). A separate 32-bit memory-mapped status word reads as zero. Only full-word accesses to it are valid.

Top module: `sysio_regbank`

## Requirements
- R1: After the synchronous active-high reset, soft_reset_o is 0, io_map_nc_o is 1 and err_halt_o is 0. Reads of port 0x092 and 0x81C return 0x00, and a read of port 0x850 returns 0x01.
- R2: A write to port 0x092 stores data bit 0 (named bit 7) as the soft-reset flag. soft_reset_o shows it from the cycle after the write, and a read of 0x092 returns {7'b0, flag}.
- R3: A write to port 0x092 with data bit 1 (named bit 6, the little-endian request) set raises err_halt_o from the next cycle. It stays high until reset, whatever is written later.
- R4: A write to port 0x81C stores data AND 0xF0 (named bits 0..3). A read of 0x81C returns the stored byte.
- R5: A write to port 0x850 stores data bit 0 as the non-contiguous map flag. io_map_nc_o shows it from the next cycle, and a read of 0x850 returns {7'b0, flag}.
- R6: Port 0x80C reads cfg_equip and port 0x852 reads cfg_board_id. Writes to either port change no output and no readable value.
- R7: Port 0x818 reads 0x00. Writes to 0x808, 0x810, 0x812 and 0x814 are discarded with no effect on any output or readable port.
- R8: A read of any port not named in R2 and R4 to R7, including the write-only ports 0x808, 0x810, 0x812 and 0x814, returns 0xFF. Writes to undecoded ports are ignored.
- R9: io_rdata is combinational and valid in the same cycle as io_rd. It is 0x00 while io_rd is low.
- R10: A memory read with mem_bytes = 4 at address 0xBFFFEFF0 gives mem_ack = 1 and mem_rdata = 0. Any other size or offset inside 0xBFFFEFF0..0xBFFFEFF3 gives mem_fault = 1. Addresses outside that range give neither. These outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| cfg_equip | input | 8 | Equipment strap value |
| cfg_board_id | input | 8 | Board identification strap value |
| mem_rd | input | 1 | Memory read strobe |
| mem_addr | input | 32 | Memory byte address |
| mem_bytes | input | 3 | Memory access size in bytes |
| mem_rdata | output | 32 | Memory read data |
| mem_ack | output | 1 | Valid access to the status word |
| mem_fault | output | 1 | Invalid-size or misaligned access in the window |
| soft_reset_o | output | 1 | Soft-reset level |
| io_map_nc_o | output | 1 | Non-contiguous I/O map select |
| err_halt_o | output | 1 | Sticky unsupported-mode halt |

## Verification
Directed writes set each data bit on its own, then all ones and all zeros, at every stateful port. This separates correct masking from shifted or inverted bit numbering, and it shows the little-endian bit apart from the soft-reset bit. A long random mix of reads and writes then spreads over the decoded ports, the write-only ports, their close neighbours and random addresses. That mix exposes decode aliasing and a stray write enable. Memory accesses cover the aligned word, the other sizes, the unaligned offsets and the addresses just outside the window, which separates acknowledge from fault.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam logic [11:0] PA_SRESET = 12'h092;
    localparam logic [11:0] PA_LIGHT  = 12'h808;
    localparam logic [11:0] PA_EQUIP  = 12'h80C;
    localparam logic [11:0] PA_PWD_A  = 12'h810;
    localparam logic [11:0] PA_PWD_B  = 12'h812;
    localparam logic [11:0] PA_CINV   = 12'h814;
    localparam logic [11:0] PA_KEY    = 12'h818;
    localparam logic [11:0] PA_SYSCTL = 12'h81C;
    localparam logic [11:0] PA_MAPSEL = 12'h850;
    localparam logic [11:0] PA_BOARD  = 12'h852;

    // named bit n sits at value 1 << (7 - n)
    function automatic logic [7:0] named_bit(input int unsigned n);
        return 8'(8'd1 << (7 - n));
    endfunction

    localparam logic [7:0] SRESET_MASK = named_bit(7);
    localparam logic [7:0] LE_REQ_MASK = named_bit(6);
    localparam logic [7:0] SYSCTL_MASK = named_bit(0) | named_bit(1) |
                                         named_bit(2) | named_bit(3);
    localparam logic [7:0] MAPSEL_MASK = named_bit(7);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SRESET,
        SEL_EQUIP,
        SEL_KEY,
        SEL_SYSCTL,
        SEL_MAPSEL,
        SEL_BOARD,
        SEL_WONLY
    } port_sel_e;

    typedef struct packed {
        logic       sreset;
        logic [7:0] sysctl;
        logic       mapsel;
        logic       halt;
    } sysio_state_t;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    output port_sel_e     sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr == AW'(PA_SRESET))      sel = SEL_SRESET;
        else if (addr == AW'(PA_EQUIP))  sel = SEL_EQUIP;
        else if (addr == AW'(PA_KEY))    sel = SEL_KEY;
        else if (addr == AW'(PA_SYSCTL)) sel = SEL_SYSCTL;
        else if (addr == AW'(PA_MAPSEL)) sel = SEL_MAPSEL;
        else if (addr == AW'(PA_BOARD))  sel = SEL_BOARD;
        else if (addr == AW'(PA_LIGHT) || addr == AW'(PA_PWD_A) ||
                 addr == AW'(PA_PWD_B) || addr == AW'(PA_CINV))
            sel = SEL_WONLY;
    end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  port_sel_e    sel,
    input  logic [DW-1:0] wdata,
    output sysio_state_t state
);
    sysio_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_SRESET: begin
                    st_d.sreset = |(wdata[7:0] & SRESET_MASK);
                    if (|(wdata[7:0] & LE_REQ_MASK)) st_d.halt = 1'b1;
                end
                SEL_SYSCTL: st_d.sysctl = wdata[7:0] & SYSCTL_MASK;
                SEL_MAPSEL: st_d.mapsel = |(wdata[7:0] & MAPSEL_MASK);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sreset <= 1'b0;
            st_q.sysctl <= 8'h00;
            st_q.mapsel <= 1'b1;
            st_q.halt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

    AST_SRESET_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_SRESET) |=> (st_q.sreset == $past(wdata[0]))); // R2
    AST_HALT_RAISE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_SRESET && wdata[1]) |=> st_q.halt); // R3
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        st_q.halt |=> st_q.halt); // R3
    AST_SYSCTL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_SYSCTL) |=> (st_q.sysctl == ($past(wdata[7:0]) & 8'hF0))); // R4
    AST_MAPSEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_MAPSEL) |=> (st_q.mapsel == $past(wdata[0]))); // R5
    AST_OTHER_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (!wr || (sel != SEL_SRESET && sel != SEL_SYSCTL && sel != SEL_MAPSEL))
        |=> $stable(st_q)); // R7
endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
    parameter int            AW   = 32,
    parameter int            DW   = 32,
    parameter logic [AW-1:0] BASE = 32'hBFFF_EFF0
) (
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [2:0]    bytes,
    output logic          ack,
    output logic          fault,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORD_BYTES = DW / 8;
    localparam int          LSB        = $clog2(WORD_BYTES);

    logic in_win, exact;

    always_comb begin
        in_win = (addr[AW-1:LSB] == BASE[AW-1:LSB]);
        exact  = (addr == BASE) && (bytes == 3'(WORD_BYTES));
        ack    = rd && in_win && exact;
        fault  = rd && in_win && !exact;
        rdata  = '0;
    end
endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
    import sysio_pkg::*;
#(
    parameter int            IO_AW    = 12,
    parameter int            DW       = 8,
    parameter int            MEM_AW   = 32,
    parameter int            MEM_DW   = 32,
    parameter logic [MEM_AW-1:0] WIN_BASE = 32'hBFFF_EFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [DW-1:0]     cfg_equip,
    input  logic [DW-1:0]     cfg_board_id,
    input  logic              mem_rd,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [2:0]        mem_bytes,
    output logic [MEM_DW-1:0] mem_rdata,
    output logic              mem_ack,
    output logic              mem_fault,
    output logic              soft_reset_o,
    output logic              io_map_nc_o,
    output logic              err_halt_o
);
    port_sel_e    sel;
    sysio_state_t st;

    sysio_decode #(.AW(IO_AW)) u_decode (
        .addr (io_addr),
        .sel  (sel)
    );

    sysio_regs #(.DW(DW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (io_wr),
        .sel   (sel),
        .wdata (io_wdata),
        .state (st)
    );

    sysio_parity_win #(.AW(MEM_AW), .DW(MEM_DW), .BASE(WIN_BASE)) u_win (
        .rd    (mem_rd),
        .addr  (mem_addr),
        .bytes (mem_bytes),
        .ack   (mem_ack),
        .fault (mem_fault),
        .rdata (mem_rdata)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (sel)
                SEL_SRESET: io_rdata = DW'(st.sreset);
                SEL_EQUIP:  io_rdata = cfg_equip;
                SEL_KEY:    io_rdata = '0;
                SEL_SYSCTL: io_rdata = DW'(st.sysctl);
                SEL_MAPSEL: io_rdata = DW'(st.mapsel);
                SEL_BOARD:  io_rdata = cfg_board_id;
                default:    io_rdata = '1;
            endcase
        end
    end

    assign soft_reset_o = st.sreset;
    assign io_map_nc_o  = st.mapsel;
    assign err_halt_o   = st.halt;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0)); // R9
    AST_UNDECODED_FF: assert property (@(posedge clk) disable iff (rst)
        (io_rd && (sel == SEL_NONE || sel == SEL_WONLY)) |-> (io_rdata == '1)); // R8
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_ack && mem_fault)); // R10
    AST_MEM_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_ack |-> (mem_rdata == '0)); // R10
endmodule

// File: tb/sysio_regbank_bench.sv
module sysio_regbank_bench;
    logic        clk = 0;
    logic        rst = 0;
    logic [11:0] io_addr = '0;
    logic        io_rd = 0, io_wr = 0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [7:0]  cfg_equip = 8'hA5, cfg_board_id = 8'h3C;
    logic        mem_rd = 0;
    logic [31:0] mem_addr = '0;
    logic [2:0]  mem_bytes = '0;
    logic [31:0] mem_rdata;
    logic        mem_ack, mem_fault;
    logic        soft_reset_o, io_map_nc_o, err_halt_o;

    int tests = 0, fails = 0;
    bit done = 0;

    logic       m_sreset, m_mapsel, m_halt;
    logic [7:0] m_sysctl;

    always #4 clk = ~clk;

    sysio_regbank u_sysio_regbank (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [11:0] a);
        case (a)
            12'h092: return {7'b0, m_sreset};
            12'h80C: return cfg_equip;
            12'h818: return 8'h00;
            12'h81C: return m_sysctl;
            12'h850: return {7'b0, m_mapsel};
            12'h852: return cfg_board_id;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string req_of(logic [11:0] a);
        case (a)
            12'h092: return "R2";
            12'h80C, 12'h852: return "R6";
            12'h818: return "R7";
            12'h81C: return "R4";
            12'h850: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check_outs(string req);
        check({req, " soft_reset_o"}, soft_reset_o, m_sreset);
        check({req, " io_map_nc_o"}, io_map_nc_o, m_mapsel);
        check({req, " err_halt_o"}, err_halt_o, m_halt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; io_rd = 0; io_wr = 0; mem_rd = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_sreset = 0; m_sysctl = 8'h00; m_mapsel = 1; m_halt = 0;
    endtask

    task automatic do_write(logic [11:0] a, logic [7:0] d, string req);
        @(negedge clk);
        io_rd = 0; io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 0;
        case (a)
            12'h092: begin m_sreset = d[0]; if (d[1]) m_halt = 1; end
            12'h81C: m_sysctl = d & 8'hF0;
            12'h850: m_mapsel = d[0];
            default: ;
        endcase
        check_outs(req);
    endtask

    task automatic do_read(logic [11:0] a, string req);
        @(negedge clk);
        io_wr = 0; io_rd = 1; io_addr = a;
        #1;
        check(req, io_rdata, exp_rd(a));
        io_rd = 0;
    endtask

    task automatic do_mem(logic [31:0] a, logic [2:0] b, logic eack, logic eflt);
        @(negedge clk);
        mem_rd = 1; mem_addr = a; mem_bytes = b;
        #1;
        check("R10 ack", mem_ack, eack);
        check("R10 fault", mem_fault, eflt);
        check("R10 rdata", mem_rdata, 32'h0);
        mem_rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    logic [11:0] pool [14] = '{12'h092, 12'h808, 12'h80C, 12'h810, 12'h812,
                               12'h814, 12'h818, 12'h81C, 12'h850, 12'h852,
                               12'h093, 12'h81D, 12'h851, 12'h000};

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        check_outs("R1");
        do_read(12'h092, "R1");
        do_read(12'h81C, "R1");
        do_read(12'h850, "R1");
        // R9 idle read data
        #1 check("R9 idle", io_rdata, 8'h00);

        // R2 single bits
        do_write(12'h092, 8'h01, "R2"); do_read(12'h092, "R2");
        do_write(12'h092, 8'h80, "R2"); do_read(12'h092, "R2");
        do_write(12'h092, 8'h01, "R2");
        do_write(12'h092, 8'h00, "R2"); do_read(12'h092, "R2");
        // R4 each bit and extremes
        for (int i = 0; i < 8; i++) begin
            do_write(12'h81C, 8'(1 << i), "R4"); do_read(12'h81C, "R4");
        end
        do_write(12'h81C, 8'hFF, "R4"); do_read(12'h81C, "R4");
        // R5
        do_write(12'h850, 8'hFE, "R5"); do_read(12'h850, "R5");
        do_write(12'h850, 8'h01, "R5"); do_read(12'h850, "R5");
        do_write(12'h850, 8'h80, "R5"); do_read(12'h850, "R5");
        // R6 straps and write immunity
        do_read(12'h80C, "R6"); do_read(12'h852, "R6");
        do_write(12'h80C, 8'h00, "R6"); do_write(12'h852, 8'hFF, "R6");
        do_read(12'h80C, "R6"); do_read(12'h852, "R6");
        cfg_equip = 8'h5A; cfg_board_id = 8'hC3;
        do_read(12'h80C, "R6"); do_read(12'h852, "R6");
        // R7 discard ports and keylock read
        do_write(12'h81C, 8'h50, "R7");
        foreach (pool[i]) if (i >= 1 && i <= 5 && i != 2) begin
            do_write(pool[i], 8'hFF, "R7");
            do_read(12'h81C, "R7"); do_read(12'h092, "R7"); do_read(12'h850, "R7");
        end
        do_read(12'h818, "R7");
        // R8 write-only and undecoded reads, undecoded writes
        do_read(12'h808, "R8"); do_read(12'h814, "R8");
        do_read(12'h093, "R8"); do_read(12'hFFF, "R8");
        do_write(12'h093, 8'hFF, "R8"); do_write(12'h81D, 8'hFF, "R8");
        do_read(12'h092, "R8"); do_read(12'h81C, "R8");
        // R3 halt: raise, then persist through clean writes
        do_write(12'h092, 8'h02, "R3");
        do_write(12'h092, 8'h00, "R3");
        do_write(12'h850, 8'h00, "R3");
        check("R3 sticky", err_halt_o, 1'b1);
        do_reset();
        check_outs("R1");
        // R10 memory window
        do_mem(32'hBFFF_EFF0, 3'd4, 1, 0);
        do_mem(32'hBFFF_EFF0, 3'd1, 0, 1);
        do_mem(32'hBFFF_EFF0, 3'd2, 0, 1);
        do_mem(32'hBFFF_EFF2, 3'd4, 0, 1);
        do_mem(32'hBFFF_EFF3, 3'd1, 0, 1);
        do_mem(32'hBFFF_EFF4, 3'd4, 0, 0);
        do_mem(32'hBFFF_EFEC, 3'd4, 0, 0);
        do_mem(32'h0000_0000, 3'd4, 0, 0);
        @(negedge clk); mem_addr = 32'hBFFF_EFF0; mem_bytes = 3'd4; #1;
        check("R10 no strobe", {mem_ack, mem_fault}, 2'b00);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [7:0]  d;
            a = ($urandom % 5 == 0) ? 12'($urandom) : pool[$urandom % 14];
            d = 8'($urandom);
            if (a == 12'h092 && ($urandom % 40 != 0)) d[1] = 1'b0;
            if ($urandom % 2) do_write(a, d, req_of(a));
            else              do_read(a, req_of(a));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule